// File: doc/BRIEF.md
# Per-Event Latency Pattern Player

This block plays back stored test events onto a four-lane, byte-per-lane output stream. It is meant for a test stand that has to imitate an upstream data source. Each event sits in its own region of an internal pattern memory. The two-bit buffer number that comes with a trigger accept selects the region. The first word of a region is a header that gives the event's release delay in clock cycles. The words after it are data or idle slots, and a trailer word closes the event.

When a trigger accept arrives, the controller takes the buffer number and reads the header. It starts a cycle counter at the moment it reads the header. It then copies the event's words into an output FIFO. The FIFO is drained only once the counter has reached the event's latency. If filling took longer than the latency, draining starts as soon as filling ends. Triggers that arrive while an event is in progress wait in a short queue and are handled in order. A hard reset request empties the queue and the FIFO. After a hard reset request, and after power-on reset, nothing is played until a bunch-zero marker has been seen.

Top module: `evp_player`

## Requirements
- R1: A pattern word is 36 bits wide. Bits 31:0 are output lanes 0..3, with lane 0 in bits 7:0. Bit 35 flags a header, bit 34 a trailer and bit 33 an idle slot. Bit 32 has no effect. The memory address is {buffer[1:0], offset[7:0]}. Offset 0 holds the header, the event's words start at offset 1, and a trailer closes them.
- R2: Let a trigger be sampled on edge E while the block is idle and armed. Let the event have latency L in header bits 31:0 and N stored words before the trailer, counting idle slots. Then the first output cycle is visible L+4 cycles after E whenever L ≥ N+2.
- R3: When L < N+2, the latency has already passed by the end of the fill, and the first output cycle is visible N+6 cycles after E.
- R4: Data words leave in memory order, one per cycle, with out_valid high. The trailer and the header are never emitted.
- R5: An idle-slot word yields exactly one cycle with out_valid low and out_data zero, in its place in the sequence.
- R6: After an event, the decision output holds bits 31:0 of that event's trailer.
- R7: busy is low while the controller is idle and high while an event is being processed. out_valid is only ever high while busy is high.
- R8: The four buffer regions are independent, and each trigger plays the region its buffer number selects.
- R9: Up to four triggers that arrive while busy are kept and played in arrival order.
- R10: A hard reset request aborts the current event, discards queued triggers and stored FIFO data, and disarms the block. No output appears until a bunch-zero marker is seen. A trigger accepted while disarmed is played after that marker.
- R11: After reset, out_valid, busy and decision are zero and the block is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hrr | input | 1 | Hard reset request: flush and disarm |
| bzero | input | 1 | Bunch-zero marker; arms the block |
| wr_en | input | 1 | Pattern memory write enable |
| wr_addr | input | 10 | Pattern memory write address {buffer, offset} |
| wr_data | input | 36 | Pattern word: flags in 35:32, lanes in 31:0 |
| trig | input | 1 | Trigger accept strobe |
| trig_buf | input | 2 | Buffer number carried by the trigger |
| out_data | output | 32 | Four output lanes |
| out_valid | output | 1 | Lane data valid |
| busy | output | 1 | Controller not idle |
| decision | output | 32 | Trailer content of the last event |

## Verification
The bench builds the block with its default parameters. These give 256-word regions, a 128-entry FIFO and a 4-entry trigger queue. With them, one run can exercise a long latency of 40 cycles and a short latency of 2 cycles that the fill time overtakes. It can also put idle slots inside an event and have several regions stacked up as queued triggers. The exact first-output cycle is measured for both latency regimes. The hard reset request is applied in the middle of an event, and the bench then checks that nothing plays until a bunch-zero marker arrives.

// File: rtl/evp_pkg.sv
package evp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LATCH,
        S_HEADER,
        S_FILL,
        S_WAIT,
        S_OUT,
        S_DONE
    } evp_state_e;

    localparam int FLAG_HDR = 35;
    localparam int FLAG_TRL = 34;
    localparam int FLAG_GAP = 33;
endpackage

// File: rtl/evp_fifo.sv
module evp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t           p_d, p_q;
    logic [W-1:0]   store_q [DEPTH];
    logic           push_ok, pop_ok;

    assign empty    = (p_q.wp == p_q.rp);
    assign full     = (p_q.wp[AW] != p_q.rp[AW]) && (p_q.wp[AW-1:0] == p_q.rp[AW-1:0]);
    assign push_ok  = push && !full && !flush;
    assign pop_ok   = pop && !empty && !flush;
    assign pop_data = store_q[p_q.rp[AW-1:0]];

    always_comb begin
        p_d = p_q;
        if (flush) begin
            p_d.wp = '0;
            p_d.rp = '0;
        end else begin
            if (push_ok) p_d.wp = p_q.wp + 1'b1;
            if (pop_ok)  p_d.rp = p_q.rp + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) store_q[p_q.wp[AW-1:0]] <= push_data;
    end

    // Occupancy never exceeds the depth (R9 queue bound, R4 data FIFO bound)
    p_occupancy_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.wp - p_q.rp) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/evp_mem.sv
module evp_mem #(
    parameter int AW = 10,
    parameter int W  = 36
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cell_q[wr_addr] <= wr_data;
    end

    assign rd_data = cell_q[rd_addr];
endmodule

// File: rtl/evp_player.sv
module evp_player
    import evp_pkg::*;
#(
    parameter int BUF_BITS   = 2,
    parameter int OFS_BITS   = 8,
    parameter int LANES      = 4,
    parameter int LANE_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int TQ_DEPTH   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              hrr,
    input  logic                              bzero,
    input  logic                              wr_en,
    input  logic [BUF_BITS+OFS_BITS-1:0]      wr_addr,
    input  logic [LANES*LANE_W+3:0]           wr_data,
    input  logic                              trig,
    input  logic [BUF_BITS-1:0]               trig_buf,
    output logic [LANES*LANE_W-1:0]           out_data,
    output logic                              out_valid,
    output logic                              busy,
    output logic [LANES*LANE_W-1:0]           decision
);
    localparam int DW = LANES * LANE_W;
    localparam int MW = DW + 4;
    localparam int AW = BUF_BITS + OFS_BITS;

    typedef struct packed {
        evp_state_e          st;
        logic                armed;
        logic [BUF_BITS-1:0] bsel;
        logic [OFS_BITS-1:0] ofs;
        logic [DW-1:0]       lat;
        logic [DW-1:0]       cnt;
        logic [DW-1:0]       dout;
        logic                vout;
        logic [DW-1:0]       dec;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [MW-1:0]       mem_word;
    logic [BUF_BITS-1:0] tq_head;
    logic                tq_empty, tq_full, tq_pop;
    logic [DW:0]         df_word;
    logic                df_empty, df_full, df_push, df_pop;
    logic [DW-1:0]       cnt_next;

    evp_mem #(.AW(AW), .W(MW)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr ({r_q.bsel, r_q.ofs}),
        .rd_data (mem_word)
    );

    evp_fifo #(.W(BUF_BITS), .DEPTH(TQ_DEPTH)) u_trigq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (hrr),
        .push      (trig),
        .push_data (trig_buf),
        .pop       (tq_pop),
        .pop_data  (tq_head),
        .empty     (tq_empty),
        .full      (tq_full)
    );

    evp_fifo #(.W(DW+1), .DEPTH(FIFO_DEPTH)) u_dataq (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (hrr),
        .push      (df_push),
        .push_data ({mem_word[FLAG_GAP], mem_word[DW-1:0]}),
        .pop       (df_pop),
        .pop_data  (df_word),
        .empty     (df_empty),
        .full      (df_full)
    );

    assign cnt_next = (r_q.cnt == '1) ? r_q.cnt : r_q.cnt + 1'b1;

    always_comb begin
        r_d     = r_q;
        r_d.vout = 1'b0;
        r_d.dout = '0;
        tq_pop  = 1'b0;
        df_push = 1'b0;
        df_pop  = 1'b0;
        if (bzero) r_d.armed = 1'b1;
        unique case (r_q.st)
            S_IDLE: begin
                if (r_q.armed && !tq_empty) begin
                    tq_pop    = 1'b1;
                    r_d.bsel  = tq_head;
                    r_d.st    = S_LATCH;
                end
            end
            S_LATCH: begin
                r_d.ofs = '0;
                r_d.cnt = '0;
                r_d.st  = S_HEADER;
            end
            S_HEADER: begin
                r_d.lat = mem_word[DW-1:0];
                r_d.cnt = DW'(1);
                r_d.ofs = OFS_BITS'(1);
                r_d.st  = S_FILL;
            end
            S_FILL: begin
                r_d.cnt = cnt_next;
                if (mem_word[FLAG_TRL]) begin
                    r_d.dec = mem_word[DW-1:0];
                    r_d.st  = S_WAIT;
                end else if (df_full) begin
                    r_d.st  = S_WAIT;
                end else begin
                    df_push = 1'b1;
                    r_d.ofs = r_q.ofs + 1'b1;
                    if (r_q.ofs == '1) r_d.st = S_WAIT;
                end
            end
            S_WAIT: begin
                if (r_q.cnt >= r_q.lat) r_d.st  = S_OUT;
                else                    r_d.cnt = cnt_next;
            end
            S_OUT: begin
                if (!df_empty) begin
                    df_pop   = 1'b1;
                    r_d.vout = !df_word[DW];
                    r_d.dout = df_word[DW] ? '0 : df_word[DW-1:0];
                end else begin
                    r_d.st = S_DONE;
                end
            end
            S_DONE:  r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
        if (hrr) begin
            r_d.st    = S_IDLE;
            r_d.armed = 1'b0;
            r_d.vout  = 1'b0;
            r_d.dout  = '0;
            tq_pop    = 1'b0;
            df_push   = 1'b0;
            df_pop    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_data  = r_q.dout;
    assign out_valid = r_q.vout;
    assign busy      = (r_q.st != S_IDLE);
    assign decision  = r_q.dec;

    // R4: the fill never pushes into a full FIFO and never pushes a trailer
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        df_push |-> !df_full);
    p_trailer_kept_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        df_push |-> !mem_word[FLAG_TRL]);
    // R2/R3: draining starts only once the counter has reached the latency
    p_release_after_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_OUT && $past(r_q.st) == S_WAIT) |-> ($past(r_q.cnt) >= $past(r_q.lat)));
    // R7: valid only while busy
    p_valid_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy);
    // R5: blank lanes whenever valid is low
    p_gap_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0));
    // R10: a hard reset request leaves the block idle and silent
    p_hrr_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hrr |=> (!out_valid && !busy));
    p_disarmed_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.armed |-> !busy);
endmodule

// File: tb/sim_evp_player.sv
module sim_evp_player;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hrr = 1'b0, bzero = 1'b0, wr_en = 1'b0, trig = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic [1:0]  trig_buf = '0;
    logic [31:0] out_data, decision;
    logic        out_valid, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [31:0] exp_q[$];
    logic [32:0] ev_w [4][16];
    int          ev_n [4];
    logic [31:0] ev_dec [4];

    evp_player u0 (
        .clk(clk), .rst_n(rst_n), .hrr(hrr), .bzero(bzero),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .trig(trig), .trig_buf(trig_buf),
        .out_data(out_data), .out_valid(out_valid), .busy(busy), .decision(decision)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: R4 order, R8 region selection, R5 blank lanes
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4", "unexpected output word", {32'h0, out_data}, 64'h0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R4/R8", "output word", {32'h0, out_data}, {32'h0, e});
            end
        end else if (rst_n && busy && out_data != 32'h0) begin
            chk(1'b0, "R5", "lanes not blank while invalid", {32'h0, out_data}, 64'h0);
        end
    end

    task automatic wr(input logic [9:0] a, input logic [35:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R1 layout: header at offset 0, words from offset 1, trailer after
    task automatic load_event(input int b, input logic [31:0] lat, input int n,
                              input int gap_pos, input logic [31:0] dec);
        wr({b[1:0], 8'd0}, {4'b1000, lat});
        for (int i = 0; i < n; i++) begin
            logic [31:0] dv;
            dv = 32'hA000_0000 | (b << 16) | (i << 8) | (i * 7 + b + 1);
            if (i == gap_pos) begin
                ev_w[b][i] = {1'b1, 32'h0};
                wr({b[1:0], 8'(i + 1)}, {4'b0010, 32'hFFFF_FFFF});
            end else begin
                ev_w[b][i] = {1'b0, dv};
                // reserved bit 32 set on data words: no effect (R1)
                wr({b[1:0], 8'(i + 1)}, {4'b0001, dv});
            end
        end
        wr({b[1:0], 8'(n + 1)}, {4'b0100, dec});
        ev_n[b]   = n;
        ev_dec[b] = dec;
    endtask

    task automatic push_exp(input int b);
        for (int i = 0; i < ev_n[b]; i++)
            if (!ev_w[b][i][32]) exp_q.push_back(ev_w[b][i][31:0]);
    endtask

    task automatic fire(input int b);
        @(negedge clk);
        trig = 1'b1; trig_buf = b[1:0];
        push_exp(b);
        @(negedge clk);
        trig = 1'b0;
    endtask

    task automatic fire_timed(input int b, input int exp_k, input string req);
        int k;
        @(negedge clk);
        trig = 1'b1; trig_buf = b[1:0];
        push_exp(b);
        @(negedge clk);
        trig = 1'b0;
        k = 0;
        while (!out_valid && k < 400) begin
            @(negedge clk);
            k++;
        end
        chk(k == exp_k, req, "first output cycle after trigger", 64'(k), 64'(exp_k));
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while ((exp_q.size() != 0 || busy) && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, req, "all expected words delivered", 64'(exp_q.size()), 64'h0);
        chk(!busy, "R7", "busy low once idle", 64'(busy), 64'h0);
    endtask

    task automatic quiet(input int cycles, input string req);
        int seen;
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (out_valid || busy) seen++;
        end
        chk(seen == 0, req, "no activity while disarmed", 64'(seen), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(out_valid == 1'b0, "R11", "out_valid after reset", 64'(out_valid), 64'h0);
        chk(busy == 1'b0, "R11", "busy after reset", 64'(busy), 64'h0);
        chk(decision == 32'h0, "R11", "decision after reset", {32'h0, decision}, 64'h0);

        load_event(0, 32'd40, 3, -1, 32'hD000_0000);
        load_event(1, 32'd2, 5, 2, 32'hD111_1111);
        load_event(2, 32'd10, 4, -1, 32'hD222_2222);
        load_event(3, 32'd5, 2, -1, 32'hD333_3333);

        // R11: disarmed after reset, trigger waits for bunch-zero
        fire(3);
        quiet(50, "R11");
        @(negedge clk); bzero = 1'b1;
        @(negedge clk); bzero = 1'b0;
        drain("R11");
        chk(decision == ev_dec[3], "R6", "decision after region 3", {32'h0, decision}, {32'h0, ev_dec[3]});

        // R2: long latency, L=40, N=3 -> 44
        fire_timed(0, 44, "R2");
        drain("R2");
        chk(decision == ev_dec[0], "R6", "decision after region 0", {32'h0, decision}, {32'h0, ev_dec[0]});

        // R3 + R5: L=2, N=5 with idle slot at entry 2 -> 11
        fire_timed(1, 11, "R3");
        begin
            logic exp_v [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk(out_valid == exp_v[j], "R5", "valid pattern around idle slot",
                    64'(out_valid), 64'(exp_v[j]));
                if (!exp_v[j])
                    chk(out_data == 32'h0, "R5", "lanes during idle slot", {32'h0, out_data}, 64'h0);
            end
        end
        drain("R5");
        chk(decision == ev_dec[1], "R6", "decision after region 1", {32'h0, decision}, {32'h0, ev_dec[1]});

        // R9 + R8: queued triggers played in order
        fire(2);
        fire(3);
        fire(1);
        fire(0);
        chk(busy == 1'b1, "R7", "busy during event", 64'(busy), 64'h1);
        drain("R9");
        chk(decision == ev_dec[0], "R9", "last queued event was region 0", {32'h0, decision}, {32'h0, ev_dec[0]});

        // R10: hard reset request mid-event, with a queued trigger
        fire(0);
        fire(2);
        repeat (8) @(negedge clk);
        hrr = 1'b1;
        @(negedge clk);
        hrr = 1'b0;
        exp_q.delete();
        chk(busy == 1'b0, "R10", "busy after hard reset request", 64'(busy), 64'h0);
        quiet(70, "R10");
        fire(3);
        quiet(40, "R10");
        @(negedge clk); bzero = 1'b1;
        @(negedge clk); bzero = 1'b0;
        drain("R10");
        chk(decision == ev_dec[3], "R10", "only post-flush trigger played", {32'h0, decision}, {32'h0, ev_dec[3]});

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule